// File: doc/BRIEF.md
# Redundant Bus Clock Late-Edge Monitor

This block supervises a pair of redundant bus clock lines, called A and B, against a shared reference tick. A fast local clock samples both lines. After each reference tick the block waits for the next rising edge on each line. If that edge comes after a programmed deadline, or does not come before the following reference tick, the block records a late-edge error for that line.

The deadline is a cycle count on the sampling clock. It covers the nominal edge delay, the late allowance and the latency of the input synchroniser. At 100 MHz, a 160 ns limit gives the default of 16 cycles. Each line has a sticky error bit and an interrupt enable. A single interrupt output combines both lines.

Software clears an error by pulsing the matching bit of a write-one-to-clear input. There is no streaming data path, so every port is a plain control or status signal.

Top module: `busclk_late_monitor`

## Requirements
- R1: While `rst_n` is low and after its release, `late_status` reads 2'b00 and `irq` reads 0 until a late-edge event occurs.
- R2: Each line input passes through a two-flop synchroniser and then a rising-edge detector. Suppose `ref_tick` is sampled at clock edge E0 and the line's rising edge is detected at edge E0+n. If n is no more than `DEADLINE_CYC`, no error is recorded. If a line goes high between edges k-1 and k, its edge is detected at edge k+2.
- R3: If the first detected rising edge after a reference tick has n greater than `DEADLINE_CYC`, the line's status bit is set at that same clock edge. Bit 0 belongs to line A and bit 1 to line B.
- R4: If no rising edge is detected on a line between two reference ticks, the line's status bit is set at the edge that samples the second tick. The first reference tick after reset never raises an error.
- R5: Status bits are sticky. Bit i clears only at an edge where `clr_w1c[i]` is 1, and other bits are not affected. If an error and a clear hit the same bit at the same edge, the error wins.
- R6: `irq` is 1 exactly when some bit has both `late_status[i]` and `irq_en[i]` at 1. Changing `irq_en` alters `irq` within the same cycle and never alters `late_status`.
- R7: Only the first detected rising edge after each reference tick is judged. Later edges before the next tick are ignored, so one late edge produces exactly one error event.
- R8: Lines A and B are measured independently. An event on one line never changes the other line's status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | Reference event, a synchronous one-cycle pulse |
| line_a | input | 1 | Raw redundant clock line A (asynchronous) |
| line_b | input | 1 | Raw redundant clock line B (asynchronous) |
| irq_en | input | 2 | Interrupt enable per line (bit 0 = A, bit 1 = B) |
| clr_w1c | input | 2 | Write-one-to-clear pulse per status bit |
| late_status | output | 2 | Sticky late-edge error bits (bit 0 = A, bit 1 = B) |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench places edges on both lines at fixed offsets inside each reference window: comfortably early, exactly at the deadline, and one cycle past it. These cases locate the boundary of the comparison to the exact cycle, including the synchroniser latency. Windows with no edge at all separate the missing-edge path from the late-edge path. Windows with a second, late edge after an early one show that only the first edge is judged. Clear pulses on the wrong bit and on the right bit, combined with changes to the enable mask, distinguish stickiness from masking. A behavioural edge-index model is compared with `late_status` and `irq` on every cycle.

// File: rtl/busclk_mon_pkg.sv
package busclk_mon_pkg;
  localparam int NLINES = 2;
  localparam int LINE_A = 0;
  localparam int LINE_B = 1;

  typedef struct packed {
    logic armed;
    logic err;
  } win_flags_t;
endpackage

// File: rtl/busclk_sync_edge.sv
module busclk_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/busclk_window_timer.sv
module busclk_window_timer #(
  parameter int DEADLINE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic rise,
  output logic err
);
  import busclk_mon_pkg::*;

  localparam int CW = $clog2(DEADLINE_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DEADLINE_CYC);

  logic          armed;
  logic [CW-1:0] elapsed;
  logic          past_limit;
  win_flags_t    nxt;

  assign past_limit = (elapsed >= LIMIT);

  always_comb begin
    nxt.armed = armed;
    nxt.err   = 1'b0;
    if (ref_tick) begin
      nxt.err   = armed & (~rise | past_limit);
      nxt.armed = 1'b1;
    end else if (armed && rise) begin
      nxt.err   = past_limit;
      nxt.armed = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      elapsed <= '0;
    end else begin
      armed <= nxt.armed;
      if (ref_tick)
        elapsed <= '0;
      else if (armed && !past_limit)
        elapsed <= elapsed + 1'b1;
    end
  end

  assign err = nxt.err;
endmodule

// File: rtl/busclk_status_irq.sv
module busclk_status_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_err,
  input  logic [N-1:0] clr_w1c,
  input  logic [N-1:0] irq_en,
  output logic [N-1:0] status,
  output logic         irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr_w1c) | set_err;
  end

  assign irq = |(status & irq_en);
endmodule

// File: rtl/busclk_late_monitor.sv
module busclk_late_monitor #(
  parameter int DEADLINE_CYC = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic       line_a,
  input  logic       line_b,
  input  logic [1:0] irq_en,
  input  logic [1:0] clr_w1c,
  output logic [1:0] late_status,
  output logic       irq
);
  import busclk_mon_pkg::*;

  logic [NLINES-1:0] raw_lines;
  logic [NLINES-1:0] line_rise;
  logic [NLINES-1:0] line_err;

  assign raw_lines[LINE_A] = line_a;
  assign raw_lines[LINE_B] = line_b;

  generate
    for (genvar i = 0; i < NLINES; i++) begin : g_line
      busclk_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_lines[i]),
        .rise (line_rise[i])
      );
      busclk_window_timer #(.DEADLINE_CYC(DEADLINE_CYC)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_tick(ref_tick),
        .rise    (line_rise[i]),
        .err     (line_err[i])
      );
    end
  endgenerate

  busclk_status_irq #(.N(NLINES)) u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_err(line_err),
    .clr_w1c(clr_w1c),
    .irq_en (irq_en),
    .status (late_status),
    .irq    (irq)
  );
endmodule

// File: rtl/busclk_late_monitor_chk.sv
module busclk_late_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ref_tick,
  input logic [1:0] rise,
  input logic [1:0] irq_en,
  input logic [1:0] clr_w1c,
  input logic [1:0] status,
  input logic       irq
);
  logic seen_ref;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seen_ref <= 1'b0;
    else if (ref_tick) seen_ref <= 1'b1;
  end

  // R1: reset leaves the status clean
  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> (status == 2'b00));

  // R4: no error can exist before any reference tick
  a_r4_quiet_before_ref: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_ref |-> (status == 2'b00));

  // R5: a set bit survives unless cleared
  a_r5_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((($past(status) & ~$past(clr_w1c))) & ~status) == 2'b00));

  // R6: an enabled set bit drives the interrupt
  a_r6_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & irq_en) != 2'b00) |-> irq);

  // R6: no enables, no interrupt
  a_r6_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == 2'b00) |-> !irq);

  generate
    for (genvar i = 0; i < 2; i++) begin : g_bit
      // R3: a bit is set only at an edge sampling a tick or a detected edge
      a_r3_set_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[i]) |-> $past(ref_tick || rise[i]));
    end
  endgenerate
endmodule

bind busclk_late_monitor busclk_late_monitor_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ref_tick(ref_tick),
  .rise    (line_rise),
  .irq_en  (irq_en),
  .clr_w1c (clr_w1c),
  .status  (late_status),
  .irq     (irq)
);

// File: tb/busclk_late_monitor_tb.sv
`timescale 1ns/1ps
module busclk_late_monitor_tb;
  localparam int DL     = 16;
  localparam int PERIOD = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick = 1'b0;
  logic       line_a = 1'b0;
  logic       line_b = 1'b0;
  logic [1:0] irq_en = 2'b00;
  logic [1:0] clr_w1c = 2'b00;
  logic [1:0] late_status;
  logic       irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  busclk_late_monitor #(.DEADLINE_CYC(DL)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .line_a(line_a), .line_b(line_b), .irq_en(irq_en),
    .clr_w1c(clr_w1c), .late_status(late_status), .irq(irq)
  );

  // Behavioural model: edge indices, sample history per line
  int edge_no;
  int ref_at [2];
  bit armed  [2];
  bit hist   [2][$];
  bit mstat  [2];

  always @(posedge clk) begin
    if (!rst_n) begin
      edge_no = 0;
      for (int i = 0; i < 2; i++) begin
        armed[i] = 0; mstat[i] = 0; ref_at[i] = 0;
        hist[i] = {0, 0, 0};
      end
    end else begin
      edge_no++;
      for (int i = 0; i < 2; i++) begin
        bit raw, seen, late;
        raw  = (i == 0) ? line_a : line_b;
        // detected now if the line was sampled high two edges ago and low three ago
        seen = hist[i][1] && !hist[i][2];
        late = 0;
        if (ref_tick) begin
          if (armed[i] && (!seen || (edge_no - ref_at[i]) > DL)) late = 1;
          armed[i] = 1; ref_at[i] = edge_no;
        end else if (armed[i] && seen) begin
          late = (edge_no - ref_at[i]) > DL;
          armed[i] = 0;
        end
        mstat[i] = (mstat[i] && !clr_w1c[i]) || late;
        hist[i].push_front(raw);
        void'(hist[i].pop_back());
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      logic [1:0] es;
      logic       ei;
      es = {mstat[1], mstat[0]};
      ei = |(es & irq_en);
      checks++;
      if (late_status !== es || irq !== ei) begin
        errors++;
        $display("FAIL %s model: status=%b irq=%b expected status=%b irq=%b",
                 tag, late_status, irq, es, ei);
      end
    end
  end

  task automatic expect_now(input logic [1:0] es, input logic ei, input string rq);
    checks++;
    if (late_status !== es || irq !== ei) begin
      errors++;
      $display("FAIL %s: status=%b irq=%b expected status=%b irq=%b",
               rq, late_status, irq, es, ei);
    end
  endtask

  // da/db: offset of the line's rise (0 = none); da2: second rise on A
  task automatic window(input int da, input int db, input int da2);
    @(negedge clk); ref_tick = 1'b1;
    @(negedge clk); ref_tick = 1'b0;
    for (int j = 1; j < PERIOD; j++) begin
      if (da  != 0 && j == da)      line_a = 1'b1;
      if (da  != 0 && j == da + 4)  line_a = 1'b0;
      if (da2 != 0 && j == da2)     line_a = 1'b1;
      if (da2 != 0 && j == da2 + 4) line_a = 1'b0;
      if (db  != 0 && j == db)      line_b = 1'b1;
      if (db  != 0 && j == db + 4)  line_b = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic clear(input logic [1:0] m);
    clr_w1c = m;
    @(negedge clk);
    clr_w1c = 2'b00;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_now(2'b00, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    expect_now(2'b00, 1'b0, "R1 after release");

    // R8: edges before any tick are ignored
    tag = "R4"; line_a = 1'b1; repeat (4) @(negedge clk); line_a = 1'b0;
    repeat (4) @(negedge clk);
    expect_now(2'b00, 1'b0, "R4 edge with no tick");

    tag = "R2"; window(5, 5, 0);
    expect_now(2'b00, 1'b0, "R2 both early");

    // j=14 gives n=16 (on deadline), j=15 gives n=17 (late)
    tag = "R3"; window(14, 15, 0);
    expect_now(2'b10, 1'b0, "R3 boundary A ok B late");

    tag = "R6"; irq_en = 2'b10; @(negedge clk);
    expect_now(2'b10, 1'b1, "R6 enable raises irq");
    irq_en = 2'b01; @(negedge clk);
    expect_now(2'b10, 1'b0, "R6 mask other bit");
    irq_en = 2'b10;

    tag = "R5"; clear(2'b01);
    expect_now(2'b10, 1'b1, "R5 wrong-bit clear");
    clear(2'b10);
    expect_now(2'b00, 1'b0, "R5 matching clear");

    tag = "R4"; window(0, 5, 0);
    expect_now(2'b00, 1'b0, "R4 missing not yet judged");
    window(3, 3, 0);
    expect_now(2'b01, 1'b0, "R4 missing A flagged, masked");
    clear(2'b01);
    expect_now(2'b00, 1'b0, "R5 clear A");

    tag = "R7"; window(3, 18, 25);
    expect_now(2'b10, 1'b1, "R7 second A edge ignored, R8 B late only");
    window(5, 5, 0);
    expect_now(2'b10, 1'b1, "R5 sticky over good window");
    clear(2'b10);
    window(5, 5, 0);
    expect_now(2'b00, 1'b0, "R7 single event per late edge");

    tag = "R8"; irq_en = 2'b11;
    window(0, 0, 0);
    window(5, 5, 0);
    expect_now(2'b11, 1'b1, "R8 both missing flagged");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    checks++; errors++;
    $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule